// File: doc/BRIEF.md
# Slot-Ordered Two-Class Interrupt Controller

This block gathers 21 interrupt request lines and presents two requests to a processor core: a normal request and a fast request. Each line is latched into a pending bit on its rising edge. Software, through a small word-addressed register bus, picks the class of every source, masks sources one by one or all at once, and clears pending bits by writing ones.

Priority is not a per-source level. There are 21 priority slots, and software writes a source number into a slot. The lowest-numbered slot whose source is pending, unmasked and of the right class wins. For each class the block drives a valid flag and the winning source number, derived combinationally from the register state. A source that appears in no slot is never signalled. Register reads return data one cycle after the read strobe.

Register addresses (word addresses): 0 class, 1 mask, 2 pending, 8+n priority slot n. Other addresses read as zero, and writes to them have no effect.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, mask bits 0..20 and the global mask bit 21 are all 1, every pending bit is 0, every class bit is 0 (normal), slot n holds n, and both valid outputs are 0.
- R2: A 0-to-1 change on request line k sets pending bit k one cycle later. A line held high sets it only once, so after a clear the bit stays 0 until the line falls and rises again.
- R3: Writing the pending register (address 2) clears every pending bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R4: When a rising edge on line k and a write-1 clear of bit k fall in the same cycle, bit k stays pending.
- R5: Pending bit k is set even while mask bit k is 1, and source k is not signalled. Writing mask bit k to 0 then makes it eligible.
- R6: While mask bit 21 (global) is 1, both valid outputs are 0, whatever the pending and per-source mask bits hold.
- R7: Class register bit k (address 0) set to 1 routes source k to the fast output. Set to 0, it routes source k to the normal output.
- R8: For each class, the output index is the source held in the lowest-numbered slot whose source is pending, unmasked and of that class. The valid flag is 1 exactly when such a slot exists.
- R9: Writing data bits [4:0] to address 8+n loads slot n. A source number that sits in no slot, or a slot value of 21 or above, never produces a request.
- R10: A read strobe returns the addressed register on the read data port in the next cycle: class and pending in bits 20:0, mask in bits 21:0, slot in bits 4:0. The port reads zero in cycles without a read, and for unused addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 21 | Interrupt request lines, edge-sampled |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 22 | Write data |
| bus_rdata | output | 22 | Read data, valid the cycle after bus_rd |
| irq_valid | output | 1 | A normal-class source is requesting |
| irq_idx | output | 5 | Winning normal-class source number |
| fiq_valid | output | 1 | A fast-class source is requesting |
| fiq_idx | output | 5 | Winning fast-class source number |

## Verification
The bench builds the block with its default values: 21 sources, a 5-bit address and a 22-bit data word. At these values every slot, the global mask bit at position 21 and out-of-range slot values 21 to 31 can all be reached through the 5-bit slot field. Random traffic therefore reaches duplicate slot entries, sources missing from the slot table and slot values that match no source. All of these stress the lowest-slot-wins search in both classes.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int ADR_CLASS = 0;
  localparam int ADR_MASK  = 1;
  localparam int ADR_PEND  = 2;
  localparam int ADR_SLOT0 = 8;

  typedef enum logic {
    CLS_NORMAL = 1'b0,
    CLS_FAST   = 1'b1
  } irq_class_e;
endpackage

// File: rtl/ipc_pending.sv
module ipc_pending #(
  parameter int NUM_SRC = 21
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               clr_en,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] req_d;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] clr_mask;

  assign rise     = req_i & ~req_d;
  assign clr_mask = clr_en ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d  <= '0;
      pend_q <= '0;
    end else begin
      req_d  <= req_i;
      // a new edge overrides a clear landing on the same bit
      pend_q <= (pend_q & ~clr_mask) | rise;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ipc_regs.sv
module ipc_regs #(
  parameter int NUM_SRC = 21,
  parameter int ADDR_W  = 5,
  parameter int IDX_W   = 5,
  parameter int DATA_W  = 22
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NUM_SRC-1:0]       pend_i,
  output logic [NUM_SRC-1:0]       class_o,
  output logic [NUM_SRC:0]         mask_o,
  output logic [NUM_SRC*IDX_W-1:0] slots_o,
  output logic                     clr_en_o,
  output logic [NUM_SRC-1:0]       clr_bits_o,
  output logic [DATA_W-1:0]        rdata_o
);
  import ipc_pkg::*;

  logic [NUM_SRC-1:0] class_q;
  logic [NUM_SRC:0]   mask_q;
  logic [IDX_W-1:0]   slot_q [NUM_SRC];
  logic [DATA_W-1:0]  rd_next;
  logic [DATA_W-1:0]  rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      class_q <= '0;
      mask_q  <= '1;
    end else if (wr_en) begin
      if (addr == ADDR_W'(ADR_CLASS)) class_q <= wdata[NUM_SRC-1:0];
      if (addr == ADDR_W'(ADR_MASK))  mask_q  <= wdata[NUM_SRC:0];
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot_q[s] <= IDX_W'(s);
      else if (wr_en && addr == ADDR_W'(ADR_SLOT0 + s))
        slot_q[s] <= wdata[IDX_W-1:0];
    end
    assign slots_o[s*IDX_W +: IDX_W] = slot_q[s];
  end

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(ADR_CLASS)) rd_next[NUM_SRC-1:0] = class_q;
    if (addr == ADDR_W'(ADR_MASK))  rd_next[NUM_SRC:0]   = mask_q;
    if (addr == ADDR_W'(ADR_PEND))  rd_next[NUM_SRC-1:0] = pend_i;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (addr == ADDR_W'(ADR_SLOT0 + s)) rd_next[IDX_W-1:0] = slot_q[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_en ? rd_next : '0;
  end

  assign class_o    = class_q;
  assign mask_o     = mask_q;
  assign clr_en_o   = wr_en && (addr == ADDR_W'(ADR_PEND));
  assign clr_bits_o = wdata[NUM_SRC-1:0];
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter #(
  parameter int                  NUM_SRC = 21,
  parameter int                  IDX_W   = 5,
  parameter ipc_pkg::irq_class_e CLS     = ipc_pkg::CLS_NORMAL
) (
  input  logic [NUM_SRC-1:0]       pend_i,
  input  logic [NUM_SRC:0]         mask_i,
  input  logic [NUM_SRC-1:0]       class_i,
  input  logic [NUM_SRC*IDX_W-1:0] slots_i,
  output logic                     valid_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [NUM_SRC-1:0] of_class;
  logic [NUM_SRC-1:0] elig;
  logic [IDX_W-1:0]   cand;

  assign of_class = (CLS == ipc_pkg::CLS_FAST) ? class_i : ~class_i;
  assign elig     = pend_i & ~mask_i[NUM_SRC-1:0] & of_class
                    & {NUM_SRC{~mask_i[NUM_SRC]}};

  // scan from the last slot down so the lowest slot is left standing
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    cand    = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      cand = slots_i[s*IDX_W +: IDX_W];
      if ((int'(cand) < NUM_SRC) && elig[cand]) begin
        valid_o = 1'b1;
        idx_o   = cand;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_SRC = 21,
  parameter int ADDR_W  = 5,
  parameter int IDX_W   = $clog2(NUM_SRC),
  parameter int DATA_W  = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_valid,
  output logic [IDX_W-1:0]   irq_idx,
  output logic               fiq_valid,
  output logic [IDX_W-1:0]   fiq_idx
);
  logic [NUM_SRC-1:0]       pend_w;
  logic [NUM_SRC-1:0]       class_w;
  logic [NUM_SRC:0]         mask_w;
  logic [NUM_SRC*IDX_W-1:0] slots_w;
  logic                     clr_en_w;
  logic [NUM_SRC-1:0]       clr_bits_w;

  ipc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_i),
    .clr_en   (clr_en_w),
    .clr_bits (clr_bits_w),
    .pend_o   (pend_w)
  );

  ipc_regs #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (bus_wr),
    .rd_en      (bus_rd),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .pend_i     (pend_w),
    .class_o    (class_w),
    .mask_o     (mask_w),
    .slots_o    (slots_w),
    .clr_en_o   (clr_en_w),
    .clr_bits_o (clr_bits_w),
    .rdata_o    (bus_rdata)
  );

  ipc_arbiter #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .CLS(ipc_pkg::CLS_NORMAL)
  ) u_arb_norm (
    .pend_i  (pend_w),
    .mask_i  (mask_w),
    .class_i (class_w),
    .slots_i (slots_w),
    .valid_o (irq_valid),
    .idx_o   (irq_idx)
  );

  ipc_arbiter #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .CLS(ipc_pkg::CLS_FAST)
  ) u_arb_fast (
    .pend_i  (pend_w),
    .mask_i  (mask_w),
    .class_i (class_w),
    .slots_i (slots_w),
    .valid_o (fiq_valid),
    .idx_o   (fiq_idx)
  );
endmodule

// File: rtl/irq_prio_ctrl_checker.sv
module irq_prio_ctrl_checker #(
  parameter int NUM_SRC = 21,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] req_i,
  input logic               clr_en,
  input logic [NUM_SRC-1:0] clr_bits,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC:0]   mask,
  input logic [NUM_SRC-1:0] cls,
  input logic               irq_valid,
  input logic [IDX_W-1:0]   irq_idx,
  input logic               fiq_valid,
  input logic [IDX_W-1:0]   fiq_idx
);
  assert_global_gate_R6: assert property (@(posedge clk) disable iff (rst)
    mask[NUM_SRC] |-> (!irq_valid && !fiq_valid));

  assert_norm_eligible_R5: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (pend[irq_idx] && !mask[irq_idx] && !cls[irq_idx]));

  assert_fast_eligible_R7: assert property (@(posedge clk) disable iff (rst)
    fiq_valid |-> (pend[fiq_idx] && !mask[fiq_idx] && cls[fiq_idx]));

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    // covers R4 as well: an edge sets the bit whether or not a clear hits it
    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
      (req_i[k] && !$past(req_i[k])) |=> pend[k]);

    assert_hold_unless_cleared_R3: assert property (@(posedge clk) disable iff (rst)
      (pend[k] && !(clr_en && clr_bits[k])) |=> pend[k]);
  end
endmodule

bind irq_prio_ctrl irq_prio_ctrl_checker #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_i     (req_i),
  .clr_en    (clr_en_w),
  .clr_bits  (clr_bits_w),
  .pend      (pend_w),
  .mask      (mask_w),
  .cls       (class_w),
  .irq_valid (irq_valid),
  .irq_idx   (irq_idx),
  .fiq_valid (fiq_valid),
  .fiq_idx   (fiq_idx)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int N      = 21;
  localparam int AW     = 5;
  localparam int IW     = 5;
  localparam int DW     = N + 1;
  localparam int A_CLS  = 0;
  localparam int A_MASK = 1;
  localparam int A_PEND = 2;
  localparam int A_SLOT = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req_i = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_valid, fiq_valid;
  logic [IW-1:0] irq_idx, fiq_idx;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .req_i(req_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_valid(irq_valid), .irq_idx(irq_idx),
    .fiq_valid(fiq_valid), .fiq_idx(fiq_idx)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // reference state
  logic [N-1:0]  m_cls, m_pend, m_reqd;
  logic [N:0]    m_mask;
  logic [IW-1:0] m_slot [N];
  logic [DW-1:0] m_rd;

  task automatic model_reset();
    m_cls = '0; m_pend = '0; m_reqd = '0; m_mask = '1; m_rd = '0;
    for (int s = 0; s < N; s++) m_slot[s] = IW'(s);
  endtask

  function automatic logic [DW-1:0] ref_read(input logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    if (a == AW'(A_CLS))  v[N-1:0] = m_cls;
    if (a == AW'(A_MASK)) v = m_mask;
    if (a == AW'(A_PEND)) v[N-1:0] = m_pend;
    for (int s = 0; s < N; s++)
      if (a == AW'(A_SLOT + s)) v[IW-1:0] = m_slot[s];
    return v;
  endfunction

  function automatic logic [IW:0] ref_win(input bit fast);
    logic [IW:0] r = '0;
    for (int s = N - 1; s >= 0; s--) begin
      int src = int'(m_slot[s]);
      if (src < N)
        if (m_pend[src] && !m_mask[src] && !m_mask[N] && (m_cls[src] == fast))
          r = {1'b1, m_slot[s]};
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one bus cycle; outputs are checked 2 ns after the edge
  task automatic step(input logic [N-1:0] rq, input logic wr, input logic rd,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [N-1:0] clr;
    @(negedge clk);
    req_i = rq; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    m_rd = rd ? ref_read(a) : '0;
    @(posedge clk);
    clr    = (wr && a == AW'(A_PEND)) ? d[N-1:0] : '0;
    m_pend = (m_pend & ~clr) | (rq & ~m_reqd);
    m_reqd = rq;
    if (wr) begin
      if (a == AW'(A_CLS))  m_cls  = d[N-1:0];
      if (a == AW'(A_MASK)) m_mask = d;
      for (int s = 0; s < N; s++)
        if (a == AW'(A_SLOT + s)) m_slot[s] = d[IW-1:0];
    end
    #2;
    chk("R8 normal winner", {irq_valid, irq_idx}, ref_win(1'b0));
    chk("R7 fast winner",   {fiq_valid, fiq_idx}, ref_win(1'b1));
    chk("R10 read data",    bus_rdata, m_rd);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] rq;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    step('0, 0, 1, AW'(A_MASK), '0);
    chk("R1 mask reset", bus_rdata, 32'h3F_FFFF);
    chk("R1 outputs idle", {irq_valid, fiq_valid}, 0);
    step('0, 0, 1, AW'(A_PEND), '0);
    chk("R1 pending reset", bus_rdata, 0);
    step('0, 0, 1, AW'(A_SLOT + 5), '0);
    chk("R1 slot5 reset", bus_rdata, 5);
    step('0, 0, 1, AW'(A_CLS), '0);
    chk("R1 class reset", bus_rdata, 0);

    // R5 pending set while masked, then unmask
    rq = N'(1) << 3;
    step(rq, 0, 0, '0, '0);
    step(rq, 0, 1, AW'(A_PEND), '0);
    chk("R5 pending while masked", bus_rdata, 32'h8);
    chk("R5 masked not signalled", irq_valid, 0);
    step(rq, 1, 0, AW'(A_MASK), '0);
    chk("R5 unmask delivers", {irq_valid, irq_idx}, {1'b1, 5'd3});

    // R6 global mask
    step(rq, 1, 0, AW'(A_MASK), DW'(1) << N);
    chk("R6 global gate", {irq_valid, fiq_valid}, 0);
    step(rq, 1, 0, AW'(A_MASK), '0);

    // R3 write-0 keeps, write-1 clears; R2 held level no re-set
    step(rq, 1, 0, AW'(A_PEND), '0);
    chk("R3 zero write keeps", irq_valid, 1);
    step(rq, 1, 0, AW'(A_PEND), DW'(rq));
    chk("R3 one write clears", irq_valid, 0);
    step(rq, 0, 1, AW'(A_PEND), '0);
    chk("R2 held level once", bus_rdata, 0);

    // R4 edge and clear together
    step('0, 0, 0, '0, '0);
    step(rq, 1, 0, AW'(A_PEND), DW'(rq));
    chk("R4 edge beats clear", {irq_valid, irq_idx}, {1'b1, 5'd3});

    // R7 class routing
    step(rq, 1, 0, AW'(A_CLS), DW'(rq));
    chk("R7 fast route", {fiq_valid, fiq_idx, irq_valid}, {1'b1, 5'd3, 1'b0});
    step(rq, 1, 0, AW'(A_CLS), '0);

    // R8 slot order, R9 reprogramming
    rq = (N'(1) << 3) | (N'(1) << 12);
    step(rq, 0, 0, '0, '0);
    chk("R8 lower slot wins", irq_idx, 3);
    step(rq, 1, 0, AW'(A_SLOT), DW'(12));
    chk("R9 slot0 reprogrammed", {irq_valid, irq_idx}, {1'b1, 5'd12});
    step(rq, 1, 0, AW'(A_PEND), DW'(rq));
    step(N'(1), 0, 0, '0, '0);
    chk("R9 unslotted source silent", irq_valid, 0);
    step(N'(1), 1, 0, AW'(A_SLOT + 4), DW'(25));
    step(N'(1), 1, 0, AW'(A_SLOT + 7), DW'(0));
    chk("R9 slot7 holds source 0", {irq_valid, irq_idx}, {1'b1, 5'd0});
    step(N'(1), 0, 1, AW'(A_SLOT + 4), '0);
    chk("R10 slot readback", bus_rdata, 25);

    // random traffic
    void'($urandom(32'h5A17));
    rq = '0;
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic wr, rd;
      rq = rq ^ N'($urandom & $urandom & $urandom);
      a  = AW'($urandom_range(0, 31));
      if ($urandom_range(0, 3) == 0) a = AW'(A_PEND);
      d  = DW'($urandom);
      if (a == AW'(A_MASK)) begin
        d = DW'($urandom & $urandom);
        d[N] = ($urandom_range(0, 7) == 0);
      end
      wr = ($urandom_range(0, 2) == 0);
      rd = ($urandom_range(0, 1) == 0);
      step(rq, wr, rd, a, d);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule